// File: doc/BRIEF.md
# Stream-to-Memory Descriptor Writer

This block receives packets on a 32-bit data stream and stores them into memory buffers described by a linked list of descriptors. Each descriptor occupies nine consecutive memory words, addressed in words, and the block decodes the first four by position: word 0 holds the next-descriptor pointer, word 1 the buffer pointer, word 2 the control word, and word 3 the status word. Words 4 to 8 receive the application payload. Bits 22:0 of the control word give the buffer capacity in bytes. That capacity must be a non-zero multiple of four, because every stream beat carries four bytes. A packet longer than one buffer continues in the next descriptor of the chain.

A separate control stream delivers a five-word side-band payload for each packet. A sequencer walks the chain, and it is built as a finite state machine with these states: `S_STOP` (waiting), `S_LD_NXT`, `S_LD_BUF`, `S_LD_CTL` and `S_LD_STS` (each issues a one-word read), `S_CHK`, `S_DATA`, `S_WR_APP`, `S_WR_STS` and `S_ADV`.

The transitions are:
- `S_STOP` goes to `S_LD_NXT` when the channel is active. Active means running, not halted and not idle.
- The four load states follow one another. The read data of each load is captured in the state that follows it.
- `S_CHK` goes to `S_STOP` when the fetched status already has its complete bit set. This also sets halted. Otherwise it goes to `S_DATA`.
- `S_DATA` accepts beats. It moves to `S_WR_APP` on the last beat of a packet, or to `S_WR_STS` when the buffer is full.
- `S_WR_APP` writes the five payload words, then goes to `S_WR_STS`.
- `S_WR_STS` goes to `S_ADV`.
- `S_ADV` moves the current pointer to the next descriptor. If the descriptor just finished was the tail, it sets idle. It then returns to `S_STOP`.

Software-facing controls are reduced to plain pins: a run level, and load strobes for the current and tail pointers. Memory is a single word-wide port with a fixed one-cycle read latency.

Top module: `s2m_desc_writer`

## Requirements
- R1: A descriptor takes beats until its received byte count reaches control bits 22:0. Beat w of that descriptor is stored at buffer pointer + w. Any remaining beats of the packet go to the following descriptors.
- R2: Status bits 22:0 of each filled descriptor hold the bytes it received, four per beat.
- R3: Status bit 27 is set only in the first descriptor of a packet. The flag is re-armed by an end of packet and by reset.
- R4: The descriptor that receives the last beat gets status bit 26. The five latched payload words are written to its words 4 to 8 in order.
- R5: Every filled descriptor gets status bit 31. `done` pulses for exactly one cycle per finished packet.
- R6: A control packet of exactly five beats replaces the latched payload. A packet of any other length pulses `ctl_err` for one cycle and leaves the payload unchanged.
- R7: A fetched descriptor whose status bit 31 is already set raises `halted`, and nothing is written to it.
- R8: Finishing the tail descriptor sets `idle` and leaves `cur_ptr` at the tail's next pointer. A tail pointer load clears `idle`.
- R9: `s_ready` is low whenever the channel is not running, or is halted, or is idle.
- R10: After reset `halted` is 1, `idle` is 0 and `cur_ptr` is 0. A rising `run` clears `halted` and `idle`. A low `run` sets `halted`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Channel run level |
| cur_wr | input | 1 | Load strobe for the current pointer |
| cur_in | input | AW | Current pointer load value |
| tail_wr | input | 1 | Load strobe for the tail pointer |
| tail_in | input | AW | Tail pointer load value |
| cur_ptr | output | AW | Current descriptor pointer |
| halted | output | 1 | Channel halted |
| idle | output | 1 | Tail reached |
| s_valid | input | 1 | Data beat valid |
| s_data | input | 32 | Data beat |
| s_last | input | 1 | Last beat of packet |
| s_ready | output | 1 | Data beat accepted |
| c_valid | input | 1 | Control beat valid |
| c_data | input | 32 | Control beat |
| c_last | input | 1 | Last control beat |
| c_ready | output | 1 | Control beat accepted (always 1) |
| ctl_err | output | 1 | Control length error pulse |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after a read |
| done | output | 1 | Packet finished pulse |

## Verification
The bench sweeps buffer capacities from 4 to 16 bytes against packet lengths from 1 to 6 beats. This separates three cases:
- packets that fit exactly in one buffer;
- packets that end part-way through a buffer;
- packets that span up to six descriptors.

In each case the first/last flags, the byte counts and the spill addresses must land on the right descriptor. Every case after the first relies on the start flag having been re-armed by the previous end of packet. Short and long control packets are sent before a data packet, which shows whether the earlier good payload survives. A chain that starts on an already-complete descriptor, and a channel that is idle or stopped, show that no beat is accepted.

// File: rtl/s2m_pkg.sv
package s2m_pkg;
    localparam int DW        = 32;
    localparam int APP_WORDS = 5;
    localparam int LEN_W     = 23;
    localparam int OFF_NXT   = 0;
    localparam int OFF_BUF   = 1;
    localparam int OFF_CTL   = 2;
    localparam int OFF_STS   = 3;
    localparam int OFF_APP   = 4;
    localparam int BIT_DONE  = 31;
    localparam int BIT_SOF   = 27;
    localparam int BIT_EOF   = 26;
    localparam int BEAT_BYTES = DW / 8;

    typedef enum logic [3:0] {
        S_STOP, S_LD_NXT, S_LD_BUF, S_LD_CTL, S_LD_STS,
        S_CHK, S_DATA, S_WR_APP, S_WR_STS, S_ADV
    } eng_state_t;

    typedef logic [APP_WORDS-1:0][DW-1:0] app_vec_t;
endpackage

// File: rtl/s2m_ctl_capture.sv
module s2m_ctl_capture
    import s2m_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          c_valid,
    input  logic [DW-1:0] c_data,
    input  logic          c_last,
    output app_vec_t      app,
    output logic          ctl_err
);
    localparam int CW = $clog2(APP_WORDS + 2);
    localparam logic [CW-1:0] CNT_MAX  = CW'(APP_WORDS + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(APP_WORDS - 1);

    logic [CW-1:0] cnt;
    app_vec_t      stage;
    logic          good_end;

    assign good_end = c_valid && c_last && (cnt == CNT_LAST);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            ctl_err <= 1'b0;
        end else begin
            ctl_err <= c_valid && c_last && (cnt != CNT_LAST);
            if (c_valid) begin
                if (c_last)
                    cnt <= '0;
                else if (cnt != CNT_MAX)
                    cnt <= cnt + 1'b1;
            end
        end
    end

    for (genvar i = 0; i < APP_WORDS; i++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage[i] <= '0;
                app[i]   <= '0;
            end else begin
                if (c_valid && cnt == CW'(i))
                    stage[i] <= c_data;
                if (good_end)
                    app[i] <= (i == APP_WORDS - 1) ? c_data : stage[i];
            end
        end
    end

    // R6: an error pulse only follows a last control beat
    a_r6_err_on_last: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_err |-> $past(c_valid && c_last));
    // R6: a committed payload never coincides with an error
    a_r6_keep_on_err: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_err |-> $stable(app));
endmodule

// File: rtl/s2m_chan_state.sv
module s2m_chan_state #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          cur_wr,
    input  logic [AW-1:0] cur_in,
    input  logic          tail_wr,
    input  logic [AW-1:0] tail_in,
    input  logic          set_halt,
    input  logic          adv,
    input  logic [AW-1:0] nxt_ptr,
    output logic [AW-1:0] cur_ptr,
    output logic          halted,
    output logic          idle,
    output logic          active
);
    logic          run_q;
    logic [AW-1:0] tail_q;
    logic          run_rise;

    assign run_rise = run && !run_q;
    assign active   = run && !halted && !idle;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q   <= 1'b0;
            halted  <= 1'b1;
            idle    <= 1'b0;
            cur_ptr <= '0;
            tail_q  <= '0;
        end else begin
            run_q <= run;
            if (!run)
                halted <= 1'b1;
            else if (run_rise)
                halted <= 1'b0;
            if (set_halt)
                halted <= 1'b1;

            if (run_rise || tail_wr)
                idle <= 1'b0;
            if (adv && cur_ptr == tail_q)
                idle <= 1'b1;

            if (tail_wr)
                tail_q <= tail_in;
            if (adv)
                cur_ptr <= nxt_ptr;
            else if (cur_wr)
                cur_ptr <= cur_in;
        end
    end

    // R8: idle only rises when a descriptor is retired
    a_r8_idle_on_adv: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(idle) |-> $past(adv));
    // R10 / R7: halted only rises on a stop or a complete descriptor
    a_r7_halt_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halted) |-> $past(set_halt || !run));
endmodule

// File: rtl/s2m_engine.sv
module s2m_engine
    import s2m_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active,
    input  logic [AW-1:0] cur_ptr,
    input  app_vec_t      app,
    input  logic          s_valid,
    input  logic [DW-1:0] s_data,
    input  logic          s_last,
    output logic          s_ready,
    output logic          mem_en,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic          set_halt,
    output logic          adv,
    output logic [AW-1:0] nxt_ptr,
    output logic          done
);
    localparam int AIW = $clog2(APP_WORDS);

    eng_state_t       state, state_n;
    logic [AW-1:0]    buf_q;
    logic [LEN_W-1:0] len_q, bytes_q;
    logic [LEN_W:0]   bytes_inc;
    logic             eof_q, sof_q;
    logic [AIW-1:0]   ai_q;
    logic             beat;
    logic [DW-1:0]    sts_word;

    assign beat      = (state == S_DATA) && active && s_valid;
    assign bytes_inc = {1'b0, bytes_q} + (LEN_W+1)'(BEAT_BYTES);

    always_comb begin
        sts_word = '0;
        sts_word[LEN_W-1:0] = bytes_q;
        sts_word[BIT_DONE]  = 1'b1;
        sts_word[BIT_SOF]   = sof_q;
        sts_word[BIT_EOF]   = eof_q;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_STOP;
        else        state <= state_n;
    end

    // next state
    always_comb begin
        state_n = state;
        unique case (state)
            S_STOP:   if (active) state_n = S_LD_NXT;
            S_LD_NXT: state_n = S_LD_BUF;
            S_LD_BUF: state_n = S_LD_CTL;
            S_LD_CTL: state_n = S_LD_STS;
            S_LD_STS: state_n = S_CHK;
            S_CHK:    state_n = mem_rdata[BIT_DONE] ? S_STOP : S_DATA;
            S_DATA: begin
                if (beat) begin
                    if (s_last)
                        state_n = S_WR_APP;
                    else if (bytes_inc >= {1'b0, len_q})
                        state_n = S_WR_STS;
                end
            end
            S_WR_APP: if (ai_q == AIW'(APP_WORDS - 1)) state_n = S_WR_STS;
            S_WR_STS: state_n = S_ADV;
            S_ADV:    state_n = S_STOP;
            default:  state_n = S_STOP;
        endcase
    end

    // outputs
    always_comb begin
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = cur_ptr;
        mem_wdata = '0;
        s_ready   = 1'b0;
        set_halt  = 1'b0;
        adv       = 1'b0;
        unique case (state)
            S_LD_NXT: begin mem_en = 1'b1; mem_addr = cur_ptr + AW'(OFF_NXT); end
            S_LD_BUF: begin mem_en = 1'b1; mem_addr = cur_ptr + AW'(OFF_BUF); end
            S_LD_CTL: begin mem_en = 1'b1; mem_addr = cur_ptr + AW'(OFF_CTL); end
            S_LD_STS: begin mem_en = 1'b1; mem_addr = cur_ptr + AW'(OFF_STS); end
            S_CHK:    set_halt = mem_rdata[BIT_DONE];
            S_DATA: begin
                s_ready   = active;
                mem_en    = beat;
                mem_we    = beat;
                mem_addr  = buf_q + AW'(bytes_q / LEN_W'(BEAT_BYTES));
                mem_wdata = s_data;
            end
            S_WR_APP: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = cur_ptr + AW'(OFF_APP) + AW'(ai_q);
                mem_wdata = app[ai_q];
            end
            S_WR_STS: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = cur_ptr + AW'(OFF_STS);
                mem_wdata = sts_word;
            end
            S_ADV:    adv = 1'b1;
            default:  ;
        endcase
    end

    // descriptor datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nxt_ptr <= '0;
            buf_q   <= '0;
            len_q   <= '0;
            bytes_q <= '0;
            eof_q   <= 1'b0;
            sof_q   <= 1'b1;
            ai_q    <= '0;
            done    <= 1'b0;
        end else begin
            done <= (state == S_WR_STS) && eof_q;
            unique case (state)
                S_LD_BUF: nxt_ptr <= mem_rdata[AW-1:0];
                S_LD_CTL: buf_q   <= mem_rdata[AW-1:0];
                S_LD_STS: len_q   <= mem_rdata[LEN_W-1:0];
                S_CHK: begin
                    bytes_q <= '0;
                    eof_q   <= 1'b0;
                    ai_q    <= '0;
                end
                S_DATA: if (beat) begin
                    bytes_q <= bytes_inc[LEN_W-1:0];
                    if (s_last) eof_q <= 1'b1;
                end
                S_WR_APP: ai_q  <= ai_q + 1'b1;
                S_WR_STS: sof_q <= eof_q;
                default: ;
            endcase
        end
    end

    // R4 / R5: the done pulse follows a status write carrying complete and end flags
    a_r4_done_after_eof: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(mem_we && mem_wdata[BIT_DONE] && mem_wdata[BIT_EOF]));
    // R2: a recorded byte count never exceeds the buffer capacity
    a_r2_count_cap: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WR_STS) |-> (mem_wdata[LEN_W-1:0] <= len_q));
    // R1: data beats are only written while the beat is accepted
    a_r1_write_on_beat: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && s_ready) |-> (mem_en && mem_we));
endmodule

// File: rtl/s2m_desc_writer.sv
module s2m_desc_writer
    import s2m_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          cur_wr,
    input  logic [AW-1:0] cur_in,
    input  logic          tail_wr,
    input  logic [AW-1:0] tail_in,
    output logic [AW-1:0] cur_ptr,
    output logic          halted,
    output logic          idle,
    input  logic          s_valid,
    input  logic [31:0]   s_data,
    input  logic          s_last,
    output logic          s_ready,
    input  logic          c_valid,
    input  logic [31:0]   c_data,
    input  logic          c_last,
    output logic          c_ready,
    output logic          ctl_err,
    output logic          mem_en,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata,
    output logic          done
);
    app_vec_t      app;
    logic          active, set_halt, adv;
    logic [AW-1:0] nxt_ptr;

    assign c_ready = 1'b1;

    s2m_ctl_capture u_ctl (
        .clk(clk), .rst_n(rst_n), .c_valid(c_valid), .c_data(c_data),
        .c_last(c_last), .app(app), .ctl_err(ctl_err)
    );

    s2m_chan_state #(.AW(AW)) u_chan (
        .clk(clk), .rst_n(rst_n), .run(run), .cur_wr(cur_wr), .cur_in(cur_in),
        .tail_wr(tail_wr), .tail_in(tail_in), .set_halt(set_halt), .adv(adv),
        .nxt_ptr(nxt_ptr), .cur_ptr(cur_ptr), .halted(halted), .idle(idle),
        .active(active)
    );

    s2m_engine #(.AW(AW)) u_eng (
        .clk(clk), .rst_n(rst_n), .active(active), .cur_ptr(cur_ptr), .app(app),
        .s_valid(s_valid), .s_data(s_data), .s_last(s_last), .s_ready(s_ready),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .set_halt(set_halt),
        .adv(adv), .nxt_ptr(nxt_ptr), .done(done)
    );

    // R9: no beat is offered acceptance unless the channel is active
    a_r9_ready_gated: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |-> (run && !halted && !idle));
endmodule

// File: tb/s2m_desc_writer_test.sv
module s2m_desc_writer_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int MEM_WORDS = 512;
    localparam int BUF_BASE = 256;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run = 1'b0, cur_wr = 1'b0, tail_wr = 1'b0;
    logic [AW-1:0] cur_in = '0, tail_in = '0, cur_ptr, mem_addr;
    logic halted, idle, s_ready, c_ready, ctl_err, mem_en, mem_we, done;
    logic s_valid = 1'b0, s_last = 1'b0, c_valid = 1'b0, c_last = 1'b0;
    logic [31:0] s_data = '0, c_data = '0, mem_wdata, mem_rdata;

    logic [31:0] mem [0:MEM_WORDS-1];
    logic        bd_we = 1'b0;
    logic [8:0]  bd_addr = '0;
    logic [31:0] bd_data = '0;

    int checks = 0, errors = 0, done_cnt = 0, err_cnt = 0, cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    s2m_desc_writer #(.AW(AW)) uut (
        .clk(clk), .rst_n(rst_n), .run(run), .cur_wr(cur_wr), .cur_in(cur_in),
        .tail_wr(tail_wr), .tail_in(tail_in), .cur_ptr(cur_ptr), .halted(halted),
        .idle(idle), .s_valid(s_valid), .s_data(s_data), .s_last(s_last),
        .s_ready(s_ready), .c_valid(c_valid), .c_data(c_data), .c_last(c_last),
        .c_ready(c_ready), .ctl_err(ctl_err), .mem_en(mem_en), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .done(done)
    );

    always @(posedge clk) begin
        if (bd_we)
            mem[bd_addr] <= bd_data;
        else if (mem_en && mem_we)
            mem[mem_addr[8:0]] <= mem_wdata;
        if (mem_en && !mem_we)
            mem_rdata <= mem[mem_addr[8:0]];
    end

    always @(negedge clk) begin
        cycles <= cycles + 1;
        if (done) done_cnt <= done_cnt + 1;
        if (ctl_err) err_cnt <= err_cnt + 1;
    end

    initial begin
        wait (cycles >= 150000);
        errors++;
        $display("FAIL watchdog: actual %0d cycles, expected fewer", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] dval(int l, int p, int j);
        return 32'hA000_0000 | (l << 16) | (p << 8) | j;
    endfunction

    function automatic logic [31:0] aval(int l, int p, int i);
        return 32'hC000_0000 | (l << 16) | (p << 8) | i;
    endfunction

    task automatic bd_write(input int a, input logic [31:0] d);
        bd_we = 1'b1; bd_addr = 9'(a); bd_data = d;
        @(negedge clk);
        bd_we = 1'b0;
    endtask

    task automatic init_chain(input int l, input logic [31:0] sts0);
        for (int k = 0; k < 8; k++) begin
            bd_write(k*16 + 0, 32'((k+1)*16));
            bd_write(k*16 + 1, 32'(BUF_BASE + k*8));
            bd_write(k*16 + 2, 32'(l));
            bd_write(k*16 + 3, (k == 0) ? sts0 : 32'h0);
            for (int i = 0; i < 5; i++) bd_write(k*16 + 4 + i, 32'h0);
            for (int w = 0; w < 8; w++) bd_write(BUF_BASE + k*8 + w, 32'hDEAD_0000);
        end
    endtask

    task automatic send_ctl(input int nwords, input int l, input int p);
        for (int i = 0; i < nwords; i++) begin
            c_valid = 1'b1; c_data = aval(l, p, i); c_last = (i == nwords-1);
            @(negedge clk);
        end
        c_valid = 1'b0; c_last = 1'b0;
    endtask

    task automatic send_pkt(input int l, input int p);
        for (int j = 0; j < p; j++) begin
            int guard = 0;
            s_valid = 1'b1; s_data = dval(l, p, j); s_last = (j == p-1);
            while (!s_ready && guard < 1000) begin
                @(negedge clk);
                guard++;
            end
            @(negedge clk);
        end
        s_valid = 1'b0; s_last = 1'b0;
    endtask

    task automatic setup_chain(input int tail_idx);
        run = 1'b0;
        @(negedge clk);
        cur_wr = 1'b1; cur_in = '0;
        tail_wr = 1'b1; tail_in = AW'(tail_idx*16);
        @(negedge clk);
        cur_wr = 1'b0; tail_wr = 1'b0;
    endtask

    // one data packet of p beats into buffers of l bytes; app words from (al, ap)
    task automatic run_case(input int l, input int p, input bit new_ctl,
                            input int al, input int ap, input bit first);
        int n, d0, guard, left, bk;
        n = (4*p + l - 1) / l;
        init_chain(l, 32'h0);
        setup_chain(n-1);
        check("R8 tail load clears idle", {31'b0, idle}, 32'h0);
        if (new_ctl) send_ctl(5, l, p);
        d0 = done_cnt;
        run = 1'b1;
        @(negedge clk);
        if (first) check("R10 run rise clears halted", {31'b0, halted}, 32'h0);
        send_pkt(l, p);
        guard = 0;
        while (!idle && guard < 2000) begin @(negedge clk); guard++; end
        @(negedge clk);
        left = 4*p;
        for (int k = 0; k < n; k++) begin
            bk = (left < l) ? left : l;
            check($sformatf("R2 R5 R3 R4 status L=%0d P=%0d k=%0d", l, p, k),
                  mem[k*16+3], (32'h8000_0000 | ((k==0) ? 32'h0800_0000 : 32'h0)
                  | ((k==n-1) ? 32'h0400_0000 : 32'h0) | 32'(bk)));
            for (int w = 0; w < bk/4; w++)
                check($sformatf("R1 data L=%0d P=%0d k=%0d w=%0d", l, p, k, w),
                      mem[BUF_BASE + k*8 + w], dval(l, p, k*(l/4) + w));
            check("R1 no write past capacity", mem[BUF_BASE + k*8 + bk/4], 32'hDEAD_0000);
            left -= bk;
        end
        for (int i = 0; i < 5; i++)
            check($sformatf("R4 app word %0d L=%0d P=%0d", i, l, p),
                  mem[(n-1)*16 + 4 + i], aval(al, ap, i));
        if (n < 8) check("R8 stop after tail", mem[n*16+3], 32'h0);
        check("R5 one done pulse", 32'(done_cnt - d0), 32'h1);
        check("R8 idle after tail", {31'b0, idle}, 32'h1);
        check("R8 cur at tail next", {16'b0, cur_ptr}, 32'(n*16));
        s_valid = 1'b1;
        repeat (3) @(negedge clk);
        check("R9 no ready when idle", {31'b0, s_ready}, 32'h0);
        s_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R10 reset halted", {31'b0, halted}, 32'h1);
        check("R10 reset idle", {31'b0, idle}, 32'h0);
        check("R10 reset cur", {16'b0, cur_ptr}, 32'h0);
        check("R9 reset ready", {31'b0, s_ready}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 halted after reset", {31'b0, halted}, 32'h1);
        check("R5 no done after reset", {31'b0, done}, 32'h0);

        // sweep: capacities 4..16 bytes, packets 1..6 beats
        for (int l = 4; l <= 16; l += 4)
            for (int p = 1; p <= 6; p++)
                run_case(l, p, 1'b1, l, p, (l == 4 && p == 1));

        // R6: bad control lengths keep the last good payload
        send_ctl(5, 8, 2);
        begin
            int e0 = err_cnt;
            send_ctl(3, 1, 1);
            send_ctl(6, 2, 2);
            @(negedge clk);
            check("R6 error pulses for 3 and 6 beats", 32'(err_cnt - e0), 32'h2);
            e0 = err_cnt;
            send_ctl(5, 8, 2);
            @(negedge clk);
            check("R6 no error for 5 beats", 32'(err_cnt - e0), 32'h0);
            send_ctl(2, 3, 3);
        end
        run_case(8, 2, 1'b0, 8, 2, 1'b0);

        // R9: stopped channel does not accept
        run = 1'b0;
        s_valid = 1'b1;
        repeat (3) @(negedge clk);
        check("R10 run low sets halted", {31'b0, halted}, 32'h1);
        check("R9 no ready when stopped", {31'b0, s_ready}, 32'h0);
        s_valid = 1'b0;

        // R7: descriptor already complete
        begin
            int d0;
            init_chain(8, 32'h8000_0000);
            setup_chain(3);
            d0 = done_cnt;
            run = 1'b1;
            s_valid = 1'b1; s_data = 32'h1234_5678; s_last = 1'b1;
            repeat (20) @(negedge clk);
            check("R7 halted on complete descriptor", {31'b0, halted}, 32'h1);
            check("R7 R9 no ready when halted", {31'b0, s_ready}, 32'h0);
            check("R7 status untouched", mem[3], 32'h8000_0000);
            check("R7 buffer untouched", mem[BUF_BASE], 32'hDEAD_0000);
            check("R7 no done", 32'(done_cnt - d0), 32'h0);
            check("R7 cur not advanced", {16'b0, cur_ptr}, 32'h0);
            s_valid = 1'b0; s_last = 1'b0;
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule